// File: doc/BRIEF.md
# Dispatch Slot Throttle with Overflow Carry

This block sits in an in-order dispatch stage and decides, each clock, which of the instructions offered in program order may leave for the back end. Each offered instruction names how many micro-ops it expands into. The block holds a budget of dispatch slots for the current cycle and a carry of slots that a past oversized instruction still owes. An instruction is let through when its micro-ops fit in the slots left, or when the cycle's budget has not been touched yet. In the second case an instruction larger than the per-cycle limit leaves at once, and its excess is paid from the budgets of the following cycles.

Besides the slot budget, every lane is gated by three room signals supplied by the neighbouring units: space in the reorder buffer, free rename registers and space in the scheduler buffer. When the oldest lane that is not granted has enough slots but lacks one of these, the block raises a stall event for that cycle. It names the first missing resource in a fixed priority order and counts the stall in a saturating counter kept for each cause.

Top module: `dt_throttle`

## Requirements
- R1: After reset the slot budget equals WIDTH, the carry is zero, all three stall counters are zero and no lane is granted until one is offered.
- R2: An offered lane fits when its micro-op count is at most the slots left after the older granted lanes of the same cycle, or when those slots still equal WIDTH; a lane that does not fit is not granted.
- R3: Lanes are granted in order: lane i (lane 0 oldest) is granted only if it is valid and every older lane is granted, so an invalid or blocked lane blocks all younger lanes.
- R4: A granted lane takes its micro-ops out of the slots left; when its count exceeds the slots left, the slots drop to zero and the excess is added to the carry.
- R5: At each clock edge, with C the carry after the cycle's grants, the next budget is 0 when C >= WIDTH and WIDTH - C otherwise, and the next carry is C - WIDTH when C >= WIDTH and 0 otherwise.
- R6: While the budget of a cycle is zero, no lane is granted, even with all room signals high.
- R7: A lane is granted only when its reorder-buffer room, rename room and scheduler room inputs are all high.
- R8: The stall output is high in a cycle exactly when the oldest non-granted valid lane, reached through granted lanes only, fits in the slots but has a room input low; a lane blocked only by slots raises no stall. The cause output is 0 when there is no stall, and otherwise 1 for missing reorder-buffer room, 2 for missing rename room, 3 for missing scheduler room, the first low input in that order winning.
- R9: Each cause has a CNT_W-bit counter that rises by one at the clock edge closing a stall cycle with that cause, holds otherwise and stays at its all-ones value once reached.
- R10: A lane offering a micro-op count of zero is treated as a one-micro-op instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | LANES | Lane i offers an instruction this cycle |
| ins_uops | input | LANES*UOP_W | Micro-op count of lane i in bits [i*UOP_W +: UOP_W] |
| rob_room | input | LANES | Reorder-buffer room for lane i |
| ren_room | input | LANES | Rename register room for lane i |
| sch_room | input | LANES | Scheduler buffer room for lane i |
| grant | output | LANES | Lane i dispatches this cycle |
| stall | output | 1 | Stall event this cycle |
| stall_cause | output | 2 | 0 none, 1 reorder buffer, 2 rename, 3 scheduler |
| slots_left | output | $clog2(WIDTH+1) | Slot budget at the start of the current cycle |
| carry_left | output | UOP_W | Carry owed at the start of the current cycle |
| cnt_rob | output | CNT_W | Stalls caused by reorder-buffer room |
| cnt_ren | output | CNT_W | Stalls caused by rename room |
| cnt_sch | output | CNT_W | Stalls caused by scheduler room |

## Verification
Every cycle the assertions check that grants form an in-order prefix of valid lanes with all room inputs high, that a zero budget grants nothing, that a nonzero carry comes only with an empty budget, that the cause is zero exactly when no stall is raised, and that each counter steps or holds as its cause dictates. The arithmetic of the budget — how an oversized instruction's excess becomes carry and how that carry drains over later cycles, the fit rule at a full budget, the zero-count rule and counter saturation — is shown only by the bench's scenarios, which compare grants and the next cycle's budget and carry with hand-derived values.

// File: rtl/dt_throttle_pkg.sv
package dt_throttle_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_ROB  = 2'd1,
    CAUSE_REN  = 2'd2,
    CAUSE_SCH  = 2'd3
  } stall_cause_e;

  // A zero count still occupies one slot.
  function automatic int unsigned eff_uops(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Fit rule: room left, or the cycle's budget untouched.
  function automatic bit slot_fit(input int unsigned need,
                                  input int unsigned left,
                                  input int unsigned full);
    return (need <= left) || (left == full);
  endfunction

  // Budget granted at a cycle boundary given the owed carry.
  function automatic int unsigned edge_budget(input int unsigned owed,
                                              input int unsigned full);
    return (owed >= full) ? 0 : full - owed;
  endfunction

  // Carry remaining after a cycle boundary.
  function automatic int unsigned edge_carry(input int unsigned owed,
                                             input int unsigned full);
    return (owed >= full) ? owed - full : 0;
  endfunction

endpackage

// File: rtl/dt_lane_chain.sv
module dt_lane_chain
  import dt_throttle_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned UOP_W = 4,
  localparam int unsigned AVW  = $clog2(WIDTH + 1)
) (
  input  logic [AVW-1:0]         avail_q,
  input  logic [UOP_W-1:0]       carry_q,
  input  logic [LANES-1:0]       ins_valid,
  input  logic [LANES*UOP_W-1:0] ins_uops,
  input  logic [LANES-1:0]       rob_room,
  input  logic [LANES-1:0]       ren_room,
  input  logic [LANES-1:0]       sch_room,
  output logic [LANES-1:0]       grant,
  output logic                   stall,
  output stall_cause_e           cause,
  output logic [UOP_W-1:0]       carry_after
);

  int unsigned  left_run;
  int unsigned  owed_run;
  int unsigned  need;
  logic         chain_open;

  always_comb begin
    left_run   = 32'(avail_q);
    owed_run   = 32'(carry_q);
    chain_open = 1'b1;
    stall      = 1'b0;
    cause      = CAUSE_NONE;
    grant      = '0;
    need       = 0;
    for (int i = 0; i < int'(LANES); i++) begin
      if (chain_open && ins_valid[i]) begin
        need = eff_uops(32'(ins_uops[i*UOP_W +: UOP_W]));
        if (slot_fit(need, left_run, WIDTH)) begin
          if (rob_room[i] && ren_room[i] && sch_room[i]) begin
            grant[i] = 1'b1;
            if (need <= left_run) begin
              left_run = left_run - need;
            end else begin
              owed_run = owed_run + (need - left_run);
              left_run = 0;
            end
          end else begin
            stall      = 1'b1;
            chain_open = 1'b0;
            if (!rob_room[i])      cause = CAUSE_ROB;
            else if (!ren_room[i]) cause = CAUSE_REN;
            else                   cause = CAUSE_SCH;
          end
        end else begin
          chain_open = 1'b0;
        end
      end else begin
        chain_open = 1'b0;
      end
    end
    carry_after = UOP_W'(owed_run);
  end

endmodule

// File: rtl/dt_budget.sv
module dt_budget
  import dt_throttle_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned UOP_W = 4,
  localparam int unsigned AVW  = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UOP_W-1:0] carry_after,
  output logic [AVW-1:0]   avail_q,
  output logic [UOP_W-1:0] carry_q
);

  logic [AVW-1:0]   avail_d;
  logic [UOP_W-1:0] carry_d;

  always_comb begin
    avail_d = AVW'(edge_budget(32'(carry_after), WIDTH));
    carry_d = UOP_W'(edge_carry(32'(carry_after), WIDTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q <= AVW'(WIDTH);
      carry_q <= '0;
    end else begin
      avail_q <= avail_d;
      carry_q <= carry_d;
    end
  end

endmodule

// File: rtl/dt_sat_cnt.sv
module dt_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && (count != '1)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/dt_throttle.sv
module dt_throttle
  import dt_throttle_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned UOP_W = 4,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned AVW  = $clog2(WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       ins_valid,
  input  logic [LANES*UOP_W-1:0] ins_uops,
  input  logic [LANES-1:0]       rob_room,
  input  logic [LANES-1:0]       ren_room,
  input  logic [LANES-1:0]       sch_room,
  output logic [LANES-1:0]       grant,
  output logic                   stall,
  output logic [1:0]             stall_cause,
  output logic [AVW-1:0]         slots_left,
  output logic [UOP_W-1:0]       carry_left,
  output logic [CNT_W-1:0]       cnt_rob,
  output logic [CNT_W-1:0]       cnt_ren,
  output logic [CNT_W-1:0]       cnt_sch
);

  localparam int unsigned NCAUSE = 3;

  logic [AVW-1:0]   avail_q;
  logic [UOP_W-1:0] carry_q;
  logic [UOP_W-1:0] carry_after;
  stall_cause_e     cause;
  logic [CNT_W-1:0] cnt_all [NCAUSE];

  dt_lane_chain #(.WIDTH(WIDTH), .LANES(LANES), .UOP_W(UOP_W)) u_chain (
    .avail_q     (avail_q),
    .carry_q     (carry_q),
    .ins_valid   (ins_valid),
    .ins_uops    (ins_uops),
    .rob_room    (rob_room),
    .ren_room    (ren_room),
    .sch_room    (sch_room),
    .grant       (grant),
    .stall       (stall),
    .cause       (cause),
    .carry_after (carry_after)
  );

  dt_budget #(.WIDTH(WIDTH), .UOP_W(UOP_W)) u_budget (
    .clk         (clk),
    .rst_n       (rst_n),
    .carry_after (carry_after),
    .avail_q     (avail_q),
    .carry_q     (carry_q)
  );

  for (genvar k = 0; k < int'(NCAUSE); k++) begin : g_cnt
    dt_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (stall && (cause == stall_cause_e'(k + 1))),
      .count (cnt_all[k])
    );
  end

  assign stall_cause = cause;
  assign slots_left  = avail_q;
  assign carry_left  = carry_q;
  assign cnt_rob     = cnt_all[0];
  assign cnt_ren     = cnt_all[1];
  assign cnt_sch     = cnt_all[2];

endmodule

// File: rtl/dt_throttle_chk.sv
module dt_throttle_chk #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned UOP_W = 4,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned AVW  = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] ins_valid,
  input logic [LANES-1:0] rob_room,
  input logic [LANES-1:0] ren_room,
  input logic [LANES-1:0] sch_room,
  input logic [LANES-1:0] grant,
  input logic             stall,
  input logic [1:0]       stall_cause,
  input logic [AVW-1:0]   slots_left,
  input logic [UOP_W-1:0] carry_left,
  input logic [CNT_W-1:0] cnt_rob,
  input logic [CNT_W-1:0] cnt_ren,
  input logic [CNT_W-1:0] cnt_sch
);

  logic [LANES-1:0] grant_inc;
  assign grant_inc = grant + 1'b1;

  a_r3_prefix_order: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_inc & grant) == '0) && ((grant & ~ins_valid) == '0));

  a_r7_room_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(rob_room & ren_room & sch_room)) == '0);

  a_r6_empty_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (slots_left == '0) |-> (grant == '0));

  a_r5_carry_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_left != '0) |-> (slots_left == '0));

  a_r5_budget_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slots_left) <= WIDTH);

  a_r8_cause_vs_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall == (stall_cause != 2'd0));

  a_r9_rob_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && stall_cause == 2'd1 && cnt_rob != '1) |=>
      (cnt_rob == CNT_W'($past(cnt_rob) + 1'b1)));

  a_r9_ren_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && stall_cause == 2'd2 && cnt_ren != '1) |=>
      (cnt_ren == CNT_W'($past(cnt_ren) + 1'b1)));

  a_r9_sch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && stall_cause == 2'd3 && cnt_sch != '1) |=>
      (cnt_sch == CNT_W'($past(cnt_sch) + 1'b1)));

  a_r9_rob_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && stall_cause == 2'd1) |=> $stable(cnt_rob));

  a_r9_ren_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && stall_cause == 2'd2) |=> $stable(cnt_ren));

  a_r9_sch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && stall_cause == 2'd3) |=> $stable(cnt_sch));

endmodule

bind dt_throttle dt_throttle_chk #(
  .WIDTH(WIDTH), .LANES(LANES), .UOP_W(UOP_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ins_valid   (ins_valid),
  .rob_room    (rob_room),
  .ren_room    (ren_room),
  .sch_room    (sch_room),
  .grant       (grant),
  .stall       (stall),
  .stall_cause (stall_cause),
  .slots_left  (slots_left),
  .carry_left  (carry_left),
  .cnt_rob     (cnt_rob),
  .cnt_ren     (cnt_ren),
  .cnt_sch     (cnt_sch)
);

// File: tb/sim_dt_throttle.sv
module sim_dt_throttle;

  localparam int W  = 4;
  localparam int L  = 2;
  localparam int UW = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [L-1:0]  ins_valid = '0;
  logic [L*UW-1:0] ins_uops = '0;
  logic [L-1:0]  rob_room = '1;
  logic [L-1:0]  ren_room = '1;
  logic [L-1:0]  sch_room = '1;
  logic [L-1:0]  grant;
  logic          stall;
  logic [1:0]    stall_cause;
  logic [2:0]    slots_left;
  logic [UW-1:0] carry_left;
  logic [CW-1:0] cnt_rob, cnt_ren, cnt_sch;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dt_throttle #(.WIDTH(W), .LANES(L), .UOP_W(UW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_uops(ins_uops),
    .rob_room(rob_room), .ren_room(ren_room), .sch_room(sch_room),
    .grant(grant), .stall(stall), .stall_cause(stall_cause),
    .slots_left(slots_left), .carry_left(carry_left),
    .cnt_rob(cnt_rob), .cnt_ren(cnt_ren), .cnt_sch(cnt_sch)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: drives one cycle, checks the combinational
  // decision, then moves to the next falling edge and checks the new budget.
  task automatic cyc(input logic [1:0] v, input int u0v, input int u1v,
                     input logic [1:0] rb, input logic [1:0] rn,
                     input logic [1:0] sc, input logic [1:0] eg,
                     input logic es, input int ec, input int esl,
                     input int eca, input string tag);
    ins_valid = v;
    ins_uops  = {UW'(u1v), UW'(u0v)};
    rob_room  = rb;
    ren_room  = rn;
    sch_room  = sc;
    #1;
    check({tag, " grant"}, int'(grant), int'(eg));
    check({tag, " stall"}, int'(stall), int'(es));
    check({tag, " cause"}, int'(stall_cause), ec);
    @(negedge clk);
    check({tag, " slots"}, int'(slots_left), esl);
    check({tag, " carry"}, int'(carry_left), eca);
  endtask

  task automatic t_reset();
    check("R1 slots", int'(slots_left), W);
    check("R1 carry", int'(carry_left), 0);
    check("R1 cnt_rob", int'(cnt_rob), 0);
    check("R1 cnt_ren", int'(cnt_ren), 0);
    check("R1 cnt_sch", int'(cnt_sch), 0);
    check("R1 grant", int'(grant), 0);
  endtask

  task automatic t_fit();
    cyc(2'b11, 2, 2, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, 4, 0, "R2 two fit");
    cyc(2'b11, 3, 2, 2'b11, 2'b11, 2'b11, 2'b01, 0, 0, 4, 0, "R2 lane1 short");
    cyc(2'b11, 1, 3, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, 4, 0, "R4 exact fill");
  endtask

  task automatic t_carry();
    cyc(2'b11, 9, 1, 2'b11, 2'b11, 2'b11, 2'b01, 0, 0, 0, 1, "R4 oversize");
    cyc(2'b01, 1, 0, 2'b11, 2'b11, 2'b11, 2'b00, 0, 0, 3, 0, "R6 zero budget");
    cyc(2'b01, 4, 0, 2'b11, 2'b11, 2'b11, 2'b00, 0, 0, 4, 0, "R2 partial budget");
    cyc(2'b11, 4, 1, 2'b11, 2'b11, 2'b11, 2'b01, 0, 0, 4, 0, "R2 full width");
    cyc(2'b01, 6, 0, 2'b11, 2'b11, 2'b11, 2'b01, 0, 0, 2, 0, "R5 small carry");
    cyc(2'b11, 2, 1, 2'b11, 2'b11, 2'b11, 2'b01, 0, 0, 4, 0, "R5 reduced budget");
  endtask

  task automatic t_order();
    cyc(2'b10, 1, 1, 2'b11, 2'b11, 2'b11, 2'b00, 0, 0, 4, 0, "R3 hole blocks");
    cyc(2'b11, 1, 1, 2'b10, 2'b11, 2'b11, 2'b00, 1, 1, 4, 0, "R7 lane0 no rob");
  endtask

  task automatic t_cause();
    cyc(2'b11, 1, 1, 2'b10, 2'b10, 2'b11, 2'b00, 1, 1, 4, 0, "R8 rob first");
    cyc(2'b11, 1, 1, 2'b11, 2'b10, 2'b10, 2'b00, 1, 2, 4, 0, "R8 ren first");
    cyc(2'b11, 1, 1, 2'b11, 2'b11, 2'b10, 2'b00, 1, 3, 4, 0, "R8 sch only");
    cyc(2'b11, 1, 1, 2'b11, 2'b01, 2'b11, 2'b01, 1, 2, 4, 0, "R8 lane1 ren");
    cyc(2'b11, 4, 1, 2'b11, 2'b01, 2'b11, 2'b01, 0, 0, 4, 0, "R8 slot block no stall");
    check("R9 cnt_rob", int'(cnt_rob), 2);
    check("R9 cnt_ren", int'(cnt_ren), 2);
    check("R9 cnt_sch", int'(cnt_sch), 1);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 6; k++)
      cyc(2'b01, 1, 0, 2'b11, 2'b11, 2'b10, 2'b00, 1, 3, 4, 0, "R9 sch stall");
    check("R9 sch at max", int'(cnt_sch), 7);
    for (int k = 0; k < 2; k++)
      cyc(2'b01, 1, 0, 2'b11, 2'b11, 2'b10, 2'b00, 1, 3, 4, 0, "R9 sch stall");
    check("R9 sch saturated", int'(cnt_sch), 7);
    check("R9 rob unchanged", int'(cnt_rob), 2);
  endtask

  task automatic t_zero();
    cyc(2'b11, 3, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, 4, 0, "R10 zero fits one");
    cyc(2'b01, 8, 0, 2'b11, 2'b11, 2'b11, 2'b01, 0, 0, 0, 0, "R5 carry equals width");
    cyc(2'b01, 0, 0, 2'b11, 2'b11, 2'b11, 2'b00, 0, 0, 4, 0, "R10 zero needs slot");
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    @(negedge clk);
    t_fit();
    t_carry();
    t_order();
    t_cause();
    t_saturate();
    t_zero();
    ins_valid = '0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_bad);
    $finish;
  end

endmodule